// File: doc/BRIEF.md
# Binary Early-Late Data Phase Detector

This block is the decision core of a bang-bang clock and data recovery loop. For every received bit it is given two samples from the front end: one taken at the middle of the bit and one taken at the boundary between that bit and the one before it. Each pair arrives as synchronous inputs together with a one-cycle valid strobe. When two consecutive middle samples differ, the boundary sample shows on which side of the data transition the recovered clock sits. The block then issues a one-bit-long command to raise or lower the oscillator frequency through a charge pump.

When there is no data transition, when the loop is still acquiring frequency lock, or before a previous bit exists, the block leaves the pump in its high-impedance idle state. Two saturating tallies count the raise and lower decisions so that the loop's behaviour can be observed. They share a synchronous clear.

Top module: `early_late_pd`

## Requirements
- R1: After reset `pump_up` and `pump_dn` are 0, `pump_idle` is 1 and both tallies read 0. The stored previous middle sample resets to 0.
- R2: The first strobed bit after reset produces no decision. The outputs stay idle and the tallies do not move, whatever the samples are.
- R3: On a strobed bit whose middle sample differs from the previous bit's middle sample, if `edge_smp` equals the previous middle sample the clock is early. `pump_dn` is 1 and `pump_up` is 0 from the clock edge that takes the strobe.
- R4: On such a bit, if `edge_smp` equals the new middle sample the clock is late. `pump_up` is 1 and `pump_dn` is 0.
- R5: A strobed bit whose middle sample equals the previous one makes both pump outputs 0 and `pump_idle` 1.
- R6: `pump_up` and `pump_dn` are never 1 together. `pump_idle` is 1 exactly when both are 0.
- R7: While `track_en` is 0, both pump outputs are 0 from the next clock edge and no tally counts. The previous middle sample is still updated by strobed bits.
- R8: Pump outputs change only on a clock edge that takes a strobe, or when `track_en` is 0. Between strobes they hold their value for the whole bit.
- R9: `up_tally` and `dn_tally` each add 1 for every raise or lower decision. They saturate at 65535 (all ones, `TALLY_W` = 16) and do not wrap.
- R10: `tally_clr` = 1 sets both tallies to 0 at the next edge. This takes priority over a decision made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: a new sample pair is present |
| ctr_smp | input | 1 | Middle-of-bit data sample |
| edge_smp | input | 1 | Sample at the boundary with the previous bit |
| track_en | input | 1 | 1 = data tracking mode, 0 = forced idle |
| tally_clr | input | 1 | Synchronous clear of both tallies |
| pump_up | output | 1 | Raise frequency (clock late) |
| pump_dn | output | 1 | Lower frequency (clock early) |
| pump_idle | output | 1 | Pump held in high impedance |
| up_tally | output | 16 | Saturating count of raise decisions |
| dn_tally | output | 16 | Saturating count of lower decisions |

## Verification
Several properties are checked on every cycle: the pump commands never overlap, and idle is their exact complement. Outputs hold between strobes, and tracking-off forces idle. A bit without a transition, or with no primed history, yields idle. The tallies neither wrap nor survive a clear. The direction of each decision relative to the boundary sample, the effect of updating history while tracking is off, and reaching the saturation value after tens of thousands of decisions can only be shown by the bench's directed sequences, which compare against a model built from the requirements.

// File: rtl/el_pd_pkg.sv
package el_pd_pkg;

  typedef enum logic [1:0] {
    PD_NONE  = 2'd0,
    PD_EARLY = 2'd1,
    PD_LATE  = 2'd2
  } pd_dir_e;

  // Direction of the clock relative to a data transition.
  function automatic pd_dir_e pd_judge(input logic prev, input logic cur, input logic edg);
    if (prev == cur)      return PD_NONE;
    else if (edg == prev) return PD_EARLY;
    else                  return PD_LATE;
  endfunction

endpackage

// File: rtl/el_pd_history.sv
module el_pd_history (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic ctr_smp,
  output logic prev_q,
  output logic primed_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else if (bit_vld) begin
      prev_q   <= ctr_smp;
      primed_q <= 1'b1;
    end
  end

  assert_primed_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |=> primed_q);

  assert_history_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> (prev_q == $past(ctr_smp)));

endmodule

// File: rtl/el_pd_judge.sv
module el_pd_judge
  import el_pd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic track_en,
  input  logic primed,
  input  logic prev_ctr,
  input  logic ctr_smp,
  input  logic edge_smp,
  output logic dec_up,
  output logic dec_dn,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_idle
);

  pd_dir_e dir;
  logic    dec_act;

  assign dir     = pd_judge(prev_ctr, ctr_smp, edge_smp);
  assign dec_act = track_en & bit_vld & primed;
  assign dec_up  = dec_act & (dir == PD_LATE);
  assign dec_dn  = dec_act & (dir == PD_EARLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
    end else if (!track_en) begin
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
    end else if (bit_vld) begin
      pump_up <= dec_up;
      pump_dn <= dec_dn;
    end
  end

  assign pump_idle = ~(pump_up | pump_dn);

  assert_pump_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  assert_mode_off_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !track_en |=> pump_idle);

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && !bit_vld) |=> ($stable(pump_up) && $stable(pump_dn)));

  assert_unprimed_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !primed) |=> pump_idle);

  assert_no_transition_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && (ctr_smp == prev_ctr)) |=> pump_idle);

endmodule

// File: rtl/el_pd_tally.sv
module el_pd_tally #(
  parameter int TALLY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               inc,
  output logic [TALLY_W-1:0] cnt
);

  localparam logic [TALLY_W-1:0] TOP = {TALLY_W{1'b1}};

  function automatic logic [TALLY_W-1:0] sat_next(input logic [TALLY_W-1:0] v);
    return (v == TOP) ? v : v + TALLY_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= sat_next(cnt);
  end

  assert_tally_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !clr) |=> (cnt == TOP));

  assert_tally_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  assert_tally_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/early_late_pd.sv
module early_late_pd #(
  parameter int TALLY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_vld,
  input  logic               ctr_smp,
  input  logic               edge_smp,
  input  logic               track_en,
  input  logic               tally_clr,
  output logic               pump_up,
  output logic               pump_dn,
  output logic               pump_idle,
  output logic [TALLY_W-1:0] up_tally,
  output logic [TALLY_W-1:0] dn_tally
);

  localparam int NUM_DIR = 2;  // index 0 = raise, 1 = lower

  logic                            prev_ctr;
  logic                            primed;
  logic                            dec_up;
  logic                            dec_dn;
  logic [NUM_DIR-1:0]              dec_vec;
  logic [NUM_DIR-1:0][TALLY_W-1:0] tallies;

  el_pd_history u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .ctr_smp  (ctr_smp),
    .prev_q   (prev_ctr),
    .primed_q (primed)
  );

  el_pd_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .track_en  (track_en),
    .primed    (primed),
    .prev_ctr  (prev_ctr),
    .ctr_smp   (ctr_smp),
    .edge_smp  (edge_smp),
    .dec_up    (dec_up),
    .dec_dn    (dec_dn),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .pump_idle (pump_idle)
  );

  assign dec_vec = {dec_dn, dec_up};

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_tally
    el_pd_tally #(.TALLY_W(TALLY_W)) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tally_clr),
      .inc   (dec_vec[g]),
      .cnt   (tallies[g])
    );
  end

  assign up_tally = tallies[0];
  assign dn_tally = tallies[1];

  assert_late_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_up |=> (pump_up && !pump_dn));

  assert_early_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_dn |=> (pump_dn && !pump_up));

  assert_tally_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!track_en && !tally_clr) |=> ($stable(up_tally) && $stable(dn_tally)));

  assert_pump_idle_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pump_up, pump_dn, pump_idle}) == 1);

endmodule

// File: tb/tb_early_late_pd.sv
module tb_early_late_pd;

  localparam int W = 16;
  localparam int TOPV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0, ctr_smp = 1'b0, edge_smp = 1'b0, track_en = 1'b1, tally_clr = 1'b0;
  logic pump_up, pump_dn, pump_idle;
  logic [W-1:0] up_tally, dn_tally;

  int n_chk = 0, n_fail = 0;
  int m_prev = 0, m_primed = 0, m_up = 0, m_dn = 0, m_upc = 0, m_dnc = 0;

  always #10 clk = ~clk;  // 50 MHz

  early_late_pd #(.TALLY_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .ctr_smp(ctr_smp), .edge_smp(edge_smp),
    .track_en(track_en), .tally_clr(tally_clr), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_idle(pump_idle), .up_tally(up_tally), .dn_tally(dn_tally)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "pump_up", int'(pump_up), m_up);
    chk(req, "pump_dn", int'(pump_dn), m_dn);
    chk(req, "up_tally", int'(up_tally), m_upc);
    chk(req, "dn_tally", int'(dn_tally), m_dnc);
    // R6 on every observation
    chk("R6", "overlap", int'(pump_up & pump_dn), 0);
    chk("R6", "pump_idle", int'(pump_idle), int'(!(pump_up | pump_dn)));
  endtask

  // Drive one strobed bit (called after a falling edge), update the model.
  task automatic bit_in(input int c, input int e, input int clr);
    int up = 0, dn = 0;
    if (track_en && m_primed && c != m_prev) begin
      if (e == m_prev) dn = 1; else up = 1;
    end
    if (track_en) begin m_up = up; m_dn = dn; end
    else begin m_up = 0; m_dn = 0; end
    if (clr) begin m_upc = 0; m_dnc = 0; end
    else begin
      if (up && m_upc < TOPV) m_upc++;
      if (dn && m_dnc < TOPV) m_dnc++;
    end
    m_prev = c; m_primed = 1;
    bit_vld = 1'b1; ctr_smp = c[0]; edge_smp = e[0]; tally_clr = clr[0];
    @(negedge clk);
    bit_vld = 1'b0; tally_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "pump_up", int'(pump_up), 0);
    chk("R1", "pump_dn", int'(pump_dn), 0);
    chk("R1", "pump_idle", int'(pump_idle), 1);
    chk("R1", "up_tally", int'(up_tally), 0);
    chk("R1", "dn_tally", int'(dn_tally), 0);
  endtask

  task automatic t_first_bit;
    bit_in(1, 1, 0);  // would be late if history existed
    check_all("R2");
    chk("R2", "pump_idle", int'(pump_idle), 1);
  endtask

  task automatic t_early;
    bit_in(0, 1, 0);  // prev 1 -> 0, edge = prev
    check_all("R3");
    chk("R3", "pump_dn", int'(pump_dn), 1);
  endtask

  task automatic t_hold;
    repeat (3) @(negedge clk);
    check_all("R8");
    chk("R8", "pump_dn held", int'(pump_dn), 1);
  endtask

  task automatic t_late;
    bit_in(1, 1, 0);  // prev 0 -> 1, edge = current
    check_all("R4");
    chk("R4", "pump_up", int'(pump_up), 1);
    bit_in(0, 0, 0);  // prev 1 -> 0, edge = current
    check_all("R4");
  endtask

  task automatic t_no_trans;
    bit_in(0, 1, 0);
    check_all("R5");
    chk("R5", "pump_idle", int'(pump_idle), 1);
    bit_in(0, 0, 0);
    check_all("R5");
  endtask

  task automatic t_mode;
    bit_in(1, 1, 0);  // late, pump_up active
    check_all("R4");
    track_en = 1'b0;  // no strobe: idle at next edge
    m_up = 0; m_dn = 0;
    @(negedge clk);
    check_all("R7");
    bit_in(0, 0, 0);  // would be late; history still moves to 0
    check_all("R7");
    track_en = 1'b1;
    bit_in(1, 0, 0);  // prev must be 0: edge = prev -> early
    check_all("R7");
    chk("R7", "history update", int'(pump_dn), 1);
  endtask

  task automatic t_clear;
    bit_in(0, 0, 1);  // late decision with clear in same cycle
    check_all("R10");
    chk("R10", "up_tally", int'(up_tally), 0);
    chk("R10", "dn_tally", int'(dn_tally), 0);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < TOPV + 5; i++) begin
      int c = (m_prev == 0) ? 1 : 0;
      bit_in(c, m_prev, 0);
    end
    check_all("R9");
    chk("R9", "dn_tally saturated", int'(dn_tally), TOPV);
    bit_in((m_prev == 0) ? 1 : 0, (m_prev == 0) ? 1 : 0, 0);  // one late
    check_all("R9");
    chk("R9", "up_tally", int'(up_tally), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_bit();
    t_early();
    t_hold();
    t_late();
    t_no_trans();
    t_mode();
    t_clear();
    t_saturate();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule